// File: doc/BRIEF.md
# Detector Clock Tick Generator

This block produces the slow operating pace for a supply voltage monitor. The pace is a one-cycle enable pulse, or tick, in the system clock domain. It comes from one of two sources. The first is a low-frequency oscillator input of about 32.768 kHz, which has no fixed relation to the system clock. It is brought into the system domain by a two-flop synchronizer, and each of its rising edges gives one tick. The second is the system clock itself, divided by 512 with a 9-bit counter that gives one tick each time it wraps.

Two register inputs control the block. They are written together with a single write strobe. A source selector picks the tick source and a run bit gates the tick. Reset leaves the slow oscillator selected with the run bit clear. The source may only change while the run bit is clear. A write that tries to change the source while the run bit is set keeps the old source and sets a sticky error flag. The run-bit half of that same write still takes effect.

Top module: `svdclk_gen`

## Requirements
- R1: After reset the source selector reads 1 (slow oscillator), the run bit reads 0, the error flag reads 0 and the tick is 0. Source encoding: 1 selects the slow oscillator and 0 selects the divided system clock.
- R2: While the run bit is 0 the tick stays 0, whatever the selected source and whatever the oscillator input does.
- R3: With source 0 selected and the run bit set, the first tick is visible in the 512th cycle after the clock edge that captured the enabling write. Later ticks follow every 512 cycles, and each tick is one cycle wide.
- R4: With source 1 selected and the run bit set, every rising edge of the oscillator input gives exactly one tick, one cycle wide. Falling edges give none.
- R5: A write whose source value differs from the current source while the run bit is 1 leaves the source unchanged. The run-bit value in that same write is still applied.
- R6: Such a rejected write sets the error flag, which then stays 1 until reset.
- R7: While the run bit is 0, a write changes the source to the written value and does not set the error flag.
- R8: Clearing the run bit returns the divider to zero. After the run bit is set again, the first divided tick comes 512 cycles after the enabling edge, however far the count had gone before.
- R9: Only the selected source can produce ticks. Oscillator edges give no tick while source 0 is selected, and the divider gives no tick while source 1 is selected.
- R10: A write while the run bit is 1 that repeats the current source value is accepted without setting the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; also the source of the divided tick |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the two control fields |
| wr_src_i | input | 1 | Source value to write (1 slow oscillator, 0 divided clock) |
| wr_run_i | input | 1 | Run-bit value to write |
| lf_osc_i | input | 1 | Slow oscillator input, asynchronous to clk_i |
| src_o | output | 1 | Current source selector |
| run_o | output | 1 | Current run bit |
| err_o | output | 1 | Sticky flag for a rejected source change |
| tick_o | output | 1 | One-cycle detector enable pulse |

## Verification
The hardest case to reach from the ports is a divider stopped partway through its count. The run bit has to be cleared well after enabling and well before the wrap, and then set again. Only then does the 512-cycle gap show whether the count was cleared, because a count left standing would give an early tick. The bench enables the divided source, waits 300 cycles, disables it for a short gap, enables it again and measures the cycle of the first tick. The rejected-write path is reached by writing a changed source together with a cleared run bit while running. This shows in one write that the source field is held back while the run field still takes effect.

// File: rtl/svdclk_pkg.sv
package svdclk_pkg;

    typedef enum logic {
        SRC_FAST = 1'b0,
        SRC_SLOW = 1'b1
    } src_e;

    typedef struct packed {
        src_e src;
        logic run;
        logic err;
    } ctrl_s;

    localparam int unsigned DIV_BITS_DEF    = 9;
    localparam int unsigned SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/svdclk_ctrl.sv
module svdclk_ctrl
    import svdclk_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_en_i,
    input  logic wr_src_i,
    input  logic wr_run_i,
    output src_e src_o,
    output logic run_o,
    output logic err_o
);

    ctrl_s ctrl_d, ctrl_q;
    logic  src_change;

    assign src_change = (src_e'(wr_src_i) != ctrl_q.src);

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en_i) begin
            ctrl_d.run = wr_run_i;
            if (ctrl_q.run && src_change) begin
                ctrl_d.err = 1'b1;
            end else begin
                ctrl_d.src = src_e'(wr_src_i);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '{src: SRC_SLOW, run: 1'b0, err: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign src_o = ctrl_q.src;
    assign run_o = ctrl_q.run;
    assign err_o = ctrl_q.err;

    AST_SRC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && run_o && src_change) |=> (src_o == $past(src_o))) else $error("src changed while running"); // R5

    AST_LOCK_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && run_o && src_change) |=> err_o) else $error("rejected write left err clear"); // R6

    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o) else $error("err flag cleared"); // R6

    AST_IDLE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !run_o) |=> (src_o == src_e'($past(wr_src_i)))) else $error("idle write lost"); // R7

    AST_SAME_SRC_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && run_o && !src_change && !err_o) |=> !err_o) else $error("same-source write flagged"); // R10

endmodule

// File: rtl/svdclk_div.sv
module svdclk_div #(
    parameter int unsigned DIV_BITS = 9
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_o
);

    localparam logic [DIV_BITS-1:0] CNT_LAST = {DIV_BITS{1'b1}};

    logic [DIV_BITS-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = run_i && (cnt_q == CNT_LAST);

    AST_DIV_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (cnt_q == '0)) else $error("divider did not wrap"); // R3

    AST_DIV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (cnt_q == '0)) else $error("divider not cleared when stopped"); // R8

    AST_DIV_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o) else $error("divided tick too wide"); // R3

endmodule

// File: rtl/svdclk_lfsync.sv
module svdclk_lfsync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic lf_osc_i,
    output logic tick_o
);

    localparam int unsigned CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_d, chain_q;
    logic             rise;

    always_comb begin
        chain_d = {chain_q[CHAIN-2:0], lf_osc_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign rise   = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    assign tick_o = run_i & rise;

    AST_LF_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o) else $error("slow tick too wide"); // R4

endmodule

// File: rtl/svdclk_gen.sv
module svdclk_gen
    import svdclk_pkg::*;
#(
    parameter int unsigned DIV_BITS    = DIV_BITS_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_en_i,
    input  logic wr_src_i,
    input  logic wr_run_i,
    input  logic lf_osc_i,
    output logic src_o,
    output logic run_o,
    output logic err_o,
    output logic tick_o
);

    src_e src_q;
    logic run_q;
    logic run_fast, run_slow;
    logic fast_tick, slow_tick;

    svdclk_ctrl u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_src_i (wr_src_i),
        .wr_run_i (wr_run_i),
        .src_o    (src_q),
        .run_o    (run_q),
        .err_o    (err_o)
    );

    assign run_fast = run_q && (src_q == SRC_FAST);
    assign run_slow = run_q && (src_q == SRC_SLOW);

    svdclk_div #(.DIV_BITS(DIV_BITS)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run_fast),
        .tick_o (fast_tick)
    );

    svdclk_lfsync #(.SYNC_STAGES(SYNC_STAGES)) u_lf (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_slow),
        .lf_osc_i (lf_osc_i),
        .tick_o   (slow_tick)
    );

    assign tick_o = (src_q == SRC_SLOW) ? slow_tick : fast_tick;
    assign src_o  = src_q;
    assign run_o  = run_q;

    AST_TICK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_o |-> !tick_o) else $error("tick while stopped"); // R2

    AST_ONE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(fast_tick && slow_tick)) else $error("both sources ticking"); // R9

endmodule

// File: tb/svdclk_gen_tb_top.sv
module svdclk_gen_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic wr_src = 1'b0;
    logic wr_run = 1'b0;
    logic lf = 1'b0;
    logic src, run, err, tick;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    svdclk_gen dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .wr_en_i  (wr_en),
        .wr_src_i (wr_src),
        .wr_run_i (wr_run),
        .lf_osc_i (lf),
        .src_o    (src),
        .run_o    (run),
        .err_o    (err),
        .tick_o   (tick)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write both fields; returns at the first negedge after the capturing edge.
    task automatic do_write(input logic s, input logic r);
        @(negedge clk);
        wr_en = 1'b1; wr_src = s; wr_run = r;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Sample tick on n negedges (first sample at the current negedge); optionally toggle lf.
    task automatic watch(input int n, input int half, output int cnt, output int first,
                         output int wide);
        logic prev = 1'b0;
        cnt = 0; first = 0; wide = 0;
        for (int k = 1; k <= n; k++) begin
            if (tick) begin
                cnt++;
                if (first == 0) first = k;
                if (prev) wide = 1;
            end
            prev = tick;
            if (half > 0) lf = ((k / half) % 2) == 1;
            @(negedge clk);
        end
        lf = 1'b0;
    endtask

    task automatic t_reset();
        int c, f, w;
        @(negedge clk);
        check("R1 src", src, 1);
        check("R1 run", run, 0);
        check("R1 err", err, 0);
        check("R1 tick", tick, 0);
        watch(200, 7, c, f, w);
        check("R2 stopped slow ticks", c, 0);
    endtask

    task automatic t_slow();
        int c, f, w;
        do_write(1'b1, 1'b1);
        watch(600, 0, c, f, w);
        check("R9 no divided tick on slow source", c, 0);
        watch(5 * 16 + 8, 8, c, f, w);
        check("R4 one tick per rise", c, 5);
        check("R4 tick width", w, 0);
        do_write(1'b1, 1'b1);
        check("R10 same src no err", err, 0);
        check("R10 src kept", src, 1);
    endtask

    task automatic t_lock();
        do_write(1'b0, 1'b1);
        check("R5 src held", src, 1);
        check("R5 run applied", run, 1);
        check("R6 err set", err, 1);
        do_write(1'b0, 1'b0);
        check("R5 src held on stop write", src, 1);
        check("R5 run cleared by same write", run, 0);
        check("R6 err sticky", err, 1);
    endtask

    task automatic t_fast();
        int c, f, w;
        do_write(1'b0, 1'b0);
        check("R7 src accepted when stopped", src, 0);
        check("R6 err still set", err, 1);
        watch(600, 0, c, f, w);
        check("R2 stopped fast ticks", c, 0);
        do_write(1'b0, 1'b1);
        watch(1536, 8, c, f, w);
        check("R3 first tick cycle", f, 512);
        check("R3 tick count over 3 periods", c, 3);
        check("R3 tick width", w, 0);
        check("R9 slow edges ignored on fast source", c, 3);
    endtask

    task automatic t_restart();
        int c, f, w;
        do_write(1'b0, 1'b0);
        do_write(1'b0, 1'b1);
        repeat (300) @(negedge clk);
        do_write(1'b0, 1'b0);
        watch(10, 0, c, f, w);
        check("R2 no tick after stop", c, 0);
        do_write(1'b0, 1'b1);
        watch(600, 0, c, f, w);
        check("R8 first tick after restart", f, 512);
        check("R8 tick count", c, 1);
    endtask

    task automatic t_rst_clear();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 err cleared by reset", err, 0);
        check("R1 src after reset", src, 1);
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_slow();
        t_lock();
        t_fast();
        t_restart();
        t_rst_clear();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule